// File: doc/BRIEF.md
# Inter-access idle cycle inserter

This block sits between the bus request arbiter and the external bus sequencer. It holds back the start of the next external access until enough idle cycles have passed since the last one ended. This gives a slow device time to stop driving the shared data bus before anything else drives it. The block keeps a record of the last granted access: whether it was a read or a write, which chip-select space it targeted, and whether a DMA engine issued it. It compares that record with the pending request and from the result picks one of five programmable idle counts, or a separate DMA count.

The arbiter holds `reqValid` together with the attributes of the access. An access is accepted in a cycle where both `reqValid` and `busGrant` are high. From the cycle after acceptance, the block treats the external bus as busy until the sequencer pulses `accDone` in the last cycle of that access. Idle cycles are counted from the cycle after `accDone`. Cycles in which no request is pending also count, so a bus that has already been quiet long enough causes no further delay. Each idle setting is a 3-bit code giving 0 to 7 cycles. There is one set of codes per space, and the set used is the one of the previous access's space.

Top module: `idle_gap_inserter`

## Requirements
- R1: After reset no previous access is recorded, so the first request is granted in the same cycle it is presented.
- R2: When the previous access was a write, the next access of either direction waits for the write-follow code of the previous space.
- R3: A read followed by a write to a different space waits for the read-to-write different-space code.
- R4: A read followed by a write to the same space waits for the read-to-write same-space code.
- R5: A read followed by a read to a different space waits for the read-to-read different-space code.
- R6: A read followed by a read to the same space waits for the read-to-read same-space code.
- R7: Each setting is a 3-bit field per space. Space s occupies bits [3s+2:3s] of its configuration port, and the field used is always the one of the previous access's space.
- R8: The DMA code replaces the five-way choice. With `cfgDmaAnyEn` = 0 it applies only when both the previous and the pending access are DMA accesses. With `cfgDmaAnyEn` = 1 it applies when either of them is.
- R9: Idle cycles are counted whether or not a request is pending. A request that arrives after at least the selected number of idle cycles is granted at once, and one that arrives after g idle cycles waits max(0, N−g) more.
- R10: `busGrant` is never high without `reqValid`. It stays low from the cycle after an acceptance through the cycle in which `accDone` is high.
- R11: With an idle count N, a request presented in the first cycle after `accDone` sees `busGrant` low for exactly N cycles, then high. A code of 0 gives no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Arbiter has an access pending |
| reqWrite | input | 1 | Pending access is a write (1) or a read (0) |
| reqSpace | input | SPACE_W | Target space of the pending access |
| reqDma | input | 1 | Pending access is issued by a DMA engine |
| accDone | input | 1 | Sequencer marks the last cycle of the running access |
| cfgWrFollow | input | NUM_SPACES*CODE_W | Per-space idle code after a write |
| cfgRdWrDiff | input | NUM_SPACES*CODE_W | Per-space code, read then write to another space |
| cfgRdWrSame | input | NUM_SPACES*CODE_W | Per-space code, read then write to the same space |
| cfgRdRdDiff | input | NUM_SPACES*CODE_W | Per-space code, read then read to another space |
| cfgRdRdSame | input | NUM_SPACES*CODE_W | Per-space code, read then read to the same space |
| cfgDmaIdle | input | CODE_W | Idle code for DMA transitions |
| cfgDmaAnyEn | input | 1 | 1: DMA code when either access is DMA; 0: only when both are |
| busGrant | output | 1 | The sequencer may start the pending access in this cycle |

## Verification
The bound checker checks four properties on every cycle: no grant without a request, no grant while an access is in flight or in the cycle after an acceptance, an immediate grant before the first access, and an immediate grant once the bus has been quiet for the longest possible code. The checker does not know the configuration or the access history. Only the bench scenarios can show that the right one of the five codes, or the DMA code, is chosen for each direction, space and DMA pairing, that the field comes from the previous space, and that a partial quiet period shortens the wait by exactly the right amount.

// File: rtl/idle_gap_pkg.sv
`timescale 1ns/1ps
package idle_gap_pkg;

  // Strobes the control unit sends to the datapath each cycle
  typedef struct packed {
    logic capture;   // access accepted: record its attributes
    logic clearCnt;  // bus occupied: restart the idle count
    logic countEn;   // bus quiet: advance the idle count
  } gapStrobes_t;

  // Which programmed setting governs the pending transition
  typedef enum logic [2:0] {
    GAP_NONE,
    GAP_WR_FOLLOW,
    GAP_RW_DIFF,
    GAP_RW_SAME,
    GAP_RR_DIFF,
    GAP_RR_SAME,
    GAP_DMA
  } gapKind_t;

endpackage

// File: rtl/idle_gap_ctrl.sv
`timescale 1ns/1ps
module idle_gap_ctrl
  import idle_gap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        accDone,
  input  logic        idleMet,
  output logic        busGrant,
  output gapStrobes_t strobes
);

  logic busy;
  logic accept;

  assign busGrant = reqValid && !busy && idleMet;
  assign accept   = busGrant;

  // busy covers the cycle after acceptance through the accDone cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busy <= 1'b0;
    else if (accept)  busy <= 1'b1;
    else if (accDone) busy <= 1'b0;
  end

  always_comb begin
    strobes.capture  = accept;
    strobes.clearCnt = busy || accept;
    strobes.countEn  = !busy && !accept;
  end

endmodule

// File: rtl/idle_gap_datapath.sv
`timescale 1ns/1ps
module idle_gap_datapath
  import idle_gap_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int CODE_W     = 3,
  localparam int SPACE_W   = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
  localparam int CFG_W     = NUM_SPACES * CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  gapStrobes_t        strobes,
  input  logic               reqWrite,
  input  logic [SPACE_W-1:0] reqSpace,
  input  logic               reqDma,
  input  logic [CFG_W-1:0]   cfgWrFollow,
  input  logic [CFG_W-1:0]   cfgRdWrDiff,
  input  logic [CFG_W-1:0]   cfgRdWrSame,
  input  logic [CFG_W-1:0]   cfgRdRdDiff,
  input  logic [CFG_W-1:0]   cfgRdRdSame,
  input  logic [CODE_W-1:0]  cfgDmaIdle,
  input  logic               cfgDmaAnyEn,
  output logic               idleMet
);

  localparam logic [CODE_W-1:0] CNT_MAX = {CODE_W{1'b1}};

  // Record of the last accepted access
  logic               prevValid;
  logic               prevWrite;
  logic [SPACE_W-1:0] prevSpace;
  logic               prevDma;
  logic [CODE_W-1:0]  elapsed;

  // Per-space settings unpacked into arrays
  logic [CODE_W-1:0] wfArr  [NUM_SPACES];
  logic [CODE_W-1:0] rwdArr [NUM_SPACES];
  logic [CODE_W-1:0] rwsArr [NUM_SPACES];
  logic [CODE_W-1:0] rrdArr [NUM_SPACES];
  logic [CODE_W-1:0] rrsArr [NUM_SPACES];

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_unpack
    assign wfArr[g]  = cfgWrFollow[g*CODE_W +: CODE_W];
    assign rwdArr[g] = cfgRdWrDiff[g*CODE_W +: CODE_W];
    assign rwsArr[g] = cfgRdWrSame[g*CODE_W +: CODE_W];
    assign rrdArr[g] = cfgRdRdDiff[g*CODE_W +: CODE_W];
    assign rrsArr[g] = cfgRdRdSame[g*CODE_W +: CODE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevWrite <= 1'b0;
      prevSpace <= '0;
      prevDma   <= 1'b0;
    end else if (strobes.capture) begin
      prevValid <= 1'b1;
      prevWrite <= reqWrite;
      prevSpace <= reqSpace;
      prevDma   <= reqDma;
    end
  end

  // Saturating count of quiet cycles since the bus was last occupied
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  elapsed <= '0;
    else if (strobes.clearCnt)                  elapsed <= '0;
    else if (strobes.countEn && elapsed != CNT_MAX) elapsed <= elapsed + CODE_W'(1);
  end

  // Classify the transition from the recorded access to the pending one
  gapKind_t          gapKind;
  logic              sameSpace;
  logic              dmaHit;
  logic [CODE_W-1:0] need;

  assign sameSpace = (reqSpace == prevSpace);
  assign dmaHit    = cfgDmaAnyEn ? (prevDma || reqDma) : (prevDma && reqDma);

  always_comb begin
    gapKind = GAP_NONE;
    if (prevValid) begin
      if (dmaHit)         gapKind = GAP_DMA;
      else if (prevWrite) gapKind = GAP_WR_FOLLOW;
      else if (reqWrite)  gapKind = sameSpace ? GAP_RW_SAME : GAP_RW_DIFF;
      else                gapKind = sameSpace ? GAP_RR_SAME : GAP_RR_DIFF;
    end
  end

  always_comb begin
    unique case (gapKind)
      GAP_WR_FOLLOW: need = wfArr[prevSpace];
      GAP_RW_DIFF:   need = rwdArr[prevSpace];
      GAP_RW_SAME:   need = rwsArr[prevSpace];
      GAP_RR_DIFF:   need = rrdArr[prevSpace];
      GAP_RR_SAME:   need = rrsArr[prevSpace];
      GAP_DMA:       need = cfgDmaIdle;
      default:       need = '0;
    endcase
  end

  assign idleMet = (elapsed >= need);

endmodule

// File: rtl/idle_gap_inserter.sv
`timescale 1ns/1ps
module idle_gap_inserter
  import idle_gap_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int CODE_W     = 3,
  localparam int SPACE_W   = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
  localparam int CFG_W     = NUM_SPACES * CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [SPACE_W-1:0] reqSpace,
  input  logic               reqDma,
  input  logic               accDone,
  input  logic [CFG_W-1:0]   cfgWrFollow,
  input  logic [CFG_W-1:0]   cfgRdWrDiff,
  input  logic [CFG_W-1:0]   cfgRdWrSame,
  input  logic [CFG_W-1:0]   cfgRdRdDiff,
  input  logic [CFG_W-1:0]   cfgRdRdSame,
  input  logic [CODE_W-1:0]  cfgDmaIdle,
  input  logic               cfgDmaAnyEn,
  output logic               busGrant
);

  gapStrobes_t strobes;
  logic        idleMet;

  idle_gap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .accDone  (accDone),
    .idleMet  (idleMet),
    .busGrant (busGrant),
    .strobes  (strobes)
  );

  idle_gap_datapath #(
    .NUM_SPACES (NUM_SPACES),
    .CODE_W     (CODE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqWrite    (reqWrite),
    .reqSpace    (reqSpace),
    .reqDma      (reqDma),
    .cfgWrFollow (cfgWrFollow),
    .cfgRdWrDiff (cfgRdWrDiff),
    .cfgRdWrSame (cfgRdWrSame),
    .cfgRdRdDiff (cfgRdRdDiff),
    .cfgRdRdSame (cfgRdRdSame),
    .cfgDmaIdle  (cfgDmaIdle),
    .cfgDmaAnyEn (cfgDmaAnyEn),
    .idleMet     (idleMet)
  );

endmodule

// File: rtl/idle_gap_checker.sv
`timescale 1ns/1ps
module idle_gap_checker #(
  parameter int CODE_W = 3
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic accDone,
  input logic busGrant
);

  localparam logic [CODE_W:0] RUN_MAX = (CODE_W+1)'((2 ** CODE_W) - 1);

  logic            accept;
  logic            busyC;
  logic            everAcc;
  logic [CODE_W:0] idleRun;

  assign accept = reqValid && busGrant;

  // Bus-occupied window as seen from the handshake ports
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busyC <= 1'b0;
    else if (accept)  busyC <= 1'b1;
    else if (accDone) busyC <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       everAcc <= 1'b0;
    else if (accept) everAcc <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   idleRun <= '0;
    else if (accept || busyC)    idleRun <= '0;
    else if (idleRun != RUN_MAX) idleRun <= idleRun + 1'b1;
  end

  p_first_free_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!everAcc && reqValid) |-> busGrant);

  p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> reqValid);

  p_no_grant_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busyC |-> !busGrant);

  p_accept_blocks_next_r10: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !busGrant);

  p_long_quiet_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busyC && idleRun >= RUN_MAX) |-> busGrant);

endmodule

bind idle_gap_inserter idle_gap_checker #(.CODE_W(CODE_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .accDone  (accDone),
  .busGrant (busGrant)
);

// File: tb/test_idle_gap_inserter.sv
`timescale 1ns/1ps
module test_idle_gap_inserter;

  localparam int NUM_SPACES = 4;
  localparam int CODE_W     = 3;
  localparam int SPACE_W    = 2;
  localparam int CFG_W      = NUM_SPACES * CODE_W;
  localparam int DMA_CODE   = 5;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqWrite = 1'b0;
  logic [SPACE_W-1:0] reqSpace = '0;
  logic               reqDma = 1'b0;
  logic               accDone = 1'b0;
  logic [CFG_W-1:0]   cfgWrFollow, cfgRdWrDiff, cfgRdWrSame, cfgRdRdDiff, cfgRdRdSame;
  logic [CODE_W-1:0]  cfgDmaIdle;
  logic               cfgDmaAnyEn = 1'b0;
  logic               busGrant;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Per-space settings (bench copy, used by the expectation model)
  int wf [NUM_SPACES];
  int rwd[NUM_SPACES];
  int rws[NUM_SPACES];
  int rrd[NUM_SPACES];
  int rrs[NUM_SPACES];

  // Model of the previously granted access
  bit mPrevValid = 0;
  bit mPrevWrite = 0;
  int mPrevSpace = 0;
  bit mPrevDma   = 0;

  int    expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  idle_gap_inserter #(.NUM_SPACES(NUM_SPACES), .CODE_W(CODE_W)) i_idle_gap_inserter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSpace(reqSpace), .reqDma(reqDma), .accDone(accDone),
    .cfgWrFollow(cfgWrFollow), .cfgRdWrDiff(cfgRdWrDiff), .cfgRdWrSame(cfgRdWrSame),
    .cfgRdRdDiff(cfgRdRdDiff), .cfgRdRdSame(cfgRdRdSame),
    .cfgDmaIdle(cfgDmaIdle), .cfgDmaAnyEn(cfgDmaAnyEn), .busGrant(busGrant)
  );

  function automatic int needFor(bit w, int s, bit d);
    if (!mPrevValid) return 0;                                          // R1
    if (cfgDmaAnyEn ? (mPrevDma || d) : (mPrevDma && d)) return DMA_CODE; // R8
    if (mPrevWrite) return wf[mPrevSpace];                              // R2
    if (w) return (s == mPrevSpace) ? rws[mPrevSpace] : rwd[mPrevSpace]; // R4 / R3
    return (s == mPrevSpace) ? rrs[mPrevSpace] : rrd[mPrevSpace];       // R6 / R5
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge; waits gap quiet cycles, requests,
  // holds the bus for busyLen cycles, then pulses accDone.
  task automatic access(input bit w, input int s, input bit d, input int gap,
                        input int busyLen, input string tag);
    int need;
    int exp;
    repeat (gap) @(negedge clk);
    need = needFor(w, s, d);
    exp  = (need > gap) ? need - gap : 0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    mPrevValid = 1; mPrevWrite = w; mPrevSpace = s; mPrevDma = d;
    reqWrite = w; reqSpace = SPACE_W'(s); reqDma = d; reqValid = 1'b1;
    #1;
    while (!busGrant) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);  // acceptance edge has passed
    reqValid = 1'b0;
    if (busyLen > 1) begin
      #1 reqValid = 1'b1;
      #1 check(busGrant == 1'b0, "R10 grant while busy", int'(busGrant), 0);
      reqValid = 1'b0;
    end
    repeat (busyLen - 1) @(negedge clk);
    accDone = 1'b1;
    @(negedge clk);
    accDone = 1'b0;
  endtask

  // Monitor: measures cycles from request to grant and compares with the queue
  initial begin
    bit armed;
    int waitCnt;
    int exp;
    string tag;
    armed = 1; waitCnt = 0;
    forever begin
      @(negedge clk);
      #3;
      if (!reqValid) begin
        armed = 1;
        waitCnt = 0;
      end else if (armed) begin
        if (busGrant) begin
          if (expQ.size() == 0) begin
            check(1'b0, "scoreboard empty", waitCnt, -1);
          end else begin
            exp = expQ.pop_front();
            tag = tagQ.pop_front();
            check(waitCnt == exp, tag, waitCnt, exp);
          end
          armed = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  initial begin
    for (int s = 0; s < NUM_SPACES; s++) begin
      wf[s]  = s + 1;
      rwd[s] = 6 - s;
      rws[s] = s;
      rrd[s] = 7 - s;
      rrs[s] = (2 * s) % 8;
      cfgWrFollow[s*CODE_W +: CODE_W] = CODE_W'(wf[s]);
      cfgRdWrDiff[s*CODE_W +: CODE_W] = CODE_W'(rwd[s]);
      cfgRdWrSame[s*CODE_W +: CODE_W] = CODE_W'(rws[s]);
      cfgRdRdDiff[s*CODE_W +: CODE_W] = CODE_W'(rrd[s]);
      cfgRdRdSame[s*CODE_W +: CODE_W] = CODE_W'(rrs[s]);
    end
    cfgDmaIdle = CODE_W'(DMA_CODE);

    repeat (3) @(negedge clk);
    check(busGrant == 1'b0, "R10 reset state, no request", int'(busGrant), 0);
    rstN = 1'b1;
    @(negedge clk);

    access(0, 0, 0, 0, 1, "R1 first access after reset");
    access(1, 1, 0, 0, 3, "R3 read then write, other space");
    access(0, 1, 0, 0, 1, "R2 write then read");
    access(1, 1, 0, 0, 2, "R4 read then write, same space");
    access(1, 2, 0, 0, 1, "R2 write then write");
    access(0, 2, 0, 0, 1, "R2 write then read, space 2 field");
    access(0, 3, 0, 0, 1, "R5 read then read, other space");
    access(0, 3, 0, 0, 1, "R6 read then read, same space");
    access(0, 0, 0, 0, 1, "R7 field of previous space 3");
    access(0, 0, 0, 0, 1, "R11 zero code gives no wait");
    access(0, 1, 0, 0, 1, "R7 field of previous space 0");
    access(1, 3, 0, 3, 1, "R9 partial quiet period");
    access(0, 3, 0, 7, 1, "R9 long quiet period");
    access(0, 1, 1, 0, 1, "R8 one side DMA, any-enable off");
    access(0, 1, 1, 0, 1, "R8 both DMA, any-enable off");
    cfgDmaAnyEn = 1'b1;
    access(1, 2, 0, 0, 1, "R8 previous DMA, any-enable on");
    access(1, 2, 1, 0, 1, "R8 pending DMA, any-enable on");
    cfgDmaAnyEn = 1'b0;
    access(0, 0, 0, 0, 2, "R8 previous DMA only, any-enable off");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule